// File: doc/BRIEF.md
# System Control Register Block with GPIO Banks and Interrupt Combiner

This block sits on a simple 32-bit register bus with per-byte lane enables and gathers the small pieces of board control that a processor needs. It returns a fixed identification word, keeps one general-purpose scratch word, and runs two 16-bit banks of general-purpose pins. Pin output data and pin direction are never written directly. Each one has its own set register and its own clear register, so one pin can change without a read-modify-write of its neighbours. Reading a bank returns the synchronised level seen on the pads.

Seventeen interrupt sources are reported raw in a status word. A mask word gates them, and the enabled sources are ORed into a single processor interrupt line. A control word holds a 16-bit duty value, two mode bits that other logic uses, and an enable. When the enable is set, one bank pin is taken over by a pulse-width generator that compares a free-running counter with the duty value.

The bus uses word addresses: a word address is the byte offset divided by four, and the byte lanes pick which bytes are accessed. A write is taken on the clock edge where select and write are both high, with no wait states. Read data is combinational and valid in the same cycle as the select.

Top module: `syscon_regs`

## Requirements
- R1: After reset the scratch, mask and control words read 0. All pad enables and pad outputs are 0, and the interrupt line is low.
- R2: Word address 0x00 (byte 0x00) reads the identification parameter, and writes to it change nothing.
- R3: Word address 0x03 (byte 0x0c) is a 32-bit scratch word. A write updates only the bytes whose lane enable is set, and a read returns the stored word.
- R4: Each bank has a base word: bank 0 at word 0x04 (byte 0x10) and bank 1 at word 0x10 (byte 0x40). At the base word, lanes 1:0 (bits 15:0) set output-data bits. At base+1, lanes 1:0 clear output-data bits. A 1 in an enabled lane acts on the bit, and a 0 leaves it as it was. A bank's 16 data bits appear on pad_out, with bank 0 in bits 15:0 and bank 1 in bits 31:16.
- R5: Lanes 3:2 (bits 31:16) of the base word set output-enable bits, and lanes 3:2 of base+1 clear them. The result appears on pad_oe, and a pad is driven only while its bit of pad_oe is 1.
- R6: A read of a bank's base word returns the bank's pad_in level in bits 15:0, through a two-flop synchroniser. A pad change made before clock edge k is returned by reads after edge k+1, and reads between edges k and k+1 still return the old level.
- R7: The enable-set half and the two clear registers cannot be read back. Bits 31:16 of the base word read 0, and the whole of base+1 reads 0.
- R8: Word 0x09 (byte 0x24) returns the raw level of the 17 sources in bits 16:0, in the same cycle, with bits 31:17 read as 0.
- R9: Word 0x12 (byte 0x48) is the mask. Bits 16:0 are writable by lane and bits 31:17 read 0. The interrupt line is the registered OR of source AND mask, so it changes one clock edge after its inputs change.
- R10: Word 0x0F (byte 0x3c) is the control word. Bits 15:0 hold the duty value, bit 16 drives adc7_sel, bit 17 drives chan_mode, bit 18 enables the pulse generator, and bits 31:19 read 0.
- R11: While bit 18 is 1, pad 15 (bank 0 bit 15) is driven by the pulse output with pad_oe forced to 1, and its GPIO data and enable bits are ignored. When bit 18 is cleared, the pad again follows its GPIO bits.
- R12: The pulse output is high while a free-running 16-bit counter is below the duty value. Over any 65536 consecutive cycles it is high for exactly duty cycles, so a duty of 0 keeps it always low.
- R13: Unmapped word addresses (for example 0x06 and 0x0A) read 0. Writes to them change no register and no pad.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access select |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_waddr | input | 6 | Word address (byte offset / 4) |
| bus_be | input | 4 | Byte lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 when not selected for read |
| pad_in | input | 32 | Pad levels, bank 1 in 31:16 and bank 0 in 15:0 |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables, 1 = drive |
| irq_src | input | 17 | Interrupt source levels |
| cpu_irq | output | 1 | Combined masked interrupt |
| adc7_sel | output | 1 | Analog input select for channel 7 |
| chan_mode | output | 1 | 0 = all four channels receive, 1 = channels 0-1 receive and 2-3 transmit |

## Verification
Output data and direction are stored state that can only be reached through the set and clear strobes, so a wrong bit there shows on pad_out or pad_oe at the first falling edge after the faulty write. That means the bench can judge every set/clear write at once at the pins, without reading anything back. A fault in the synchroniser depth shows up as a read value that arrives one edge early or late, so the bench reads both before and after the second edge. A fault in the mask register or the interrupt stage shows on cpu_irq one edge after the source or mask changes. A fault in the pulse counter only becomes visible as a wrong count of high cycles over a full 65536-cycle period.

// File: rtl/syscon_pkg.sv
package syscon_pkg;

    parameter int DATA_W  = 32;
    parameter int ADDR_W  = 6;
    parameter int GPIO_W  = 16;
    parameter int IRQ_N   = 17;
    parameter int DUTY_W  = 16;

    // word addresses (byte offset / 4)
    localparam logic [ADDR_W-1:0] W_IDENT    = 6'h00;
    localparam logic [ADDR_W-1:0] W_SCRATCH  = 6'h03;
    localparam logic [ADDR_W-1:0] W_IRQ_STAT = 6'h09;
    localparam logic [ADDR_W-1:0] W_CTRL     = 6'h0F;
    localparam logic [ADDR_W-1:0] W_IRQ_MASK = 6'h12;

    // control word field positions
    localparam int CTL_ADC_SEL = DUTY_W;
    localparam int CTL_MODE    = DUTY_W + 1;
    localparam int CTL_PWM_EN  = DUTY_W + 2;
    localparam int CTL_W       = DUTY_W + 3;

    // base word of a GPIO bank: bank 0 at 0x04, later banks from 0x10 in pairs
    function automatic logic [ADDR_W-1:0] bank_word(input int idx);
        logic [ADDR_W-1:0] w;
        if (idx == 0) begin
            w = 6'h04;
        end else begin
            w = ADDR_W'(6'h10 + 2 * (idx - 1));
        end
        return w;
    endfunction

    // expand byte lane enables to a bit mask
    function automatic logic [DATA_W-1:0] lane_mask(input logic [DATA_W/8-1:0] be);
        logic [DATA_W-1:0] m;
        for (int b = 0; b < DATA_W / 8; b++) begin
            m[b*8 +: 8] = {8{be[b]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/syscon_gpio_bank.sv
module syscon_gpio_bank
    import syscon_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  set_we,
    input  logic                  clr_we,
    input  logic [DATA_W/8-1:0]   be,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [GPIO_W-1:0]     pad_in,
    output logic [GPIO_W-1:0]     level,
    output logic [GPIO_W-1:0]     dout,
    output logic [GPIO_W-1:0]     oe
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0][GPIO_W-1:0] sync;
        logic [GPIO_W-1:0]                  dout;
        logic [GPIO_W-1:0]                  oe;
    } bank_t;

    bank_t bank_d, bank_q;

    logic [DATA_W-1:0] wmask;
    logic [GPIO_W-1:0] data_bits;
    logic [GPIO_W-1:0] oe_bits;

    always_comb begin
        wmask     = lane_mask(be);
        data_bits = wdata[GPIO_W-1:0] & wmask[GPIO_W-1:0];
        oe_bits   = wdata[2*GPIO_W-1:GPIO_W] & wmask[2*GPIO_W-1:GPIO_W];

        bank_d      = bank_q;
        bank_d.sync = {bank_q.sync[SYNC_STAGES-2:0], pad_in};

        if (set_we) begin
            bank_d.dout = bank_q.dout | data_bits;
            bank_d.oe   = bank_q.oe   | oe_bits;
        end else if (clr_we) begin
            bank_d.dout = bank_q.dout & ~data_bits;
            bank_d.oe   = bank_q.oe   & ~oe_bits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign level = bank_q.sync[SYNC_STAGES-1];
    assign dout  = bank_q.dout;
    assign oe    = bank_q.oe;

endmodule

// File: rtl/syscon_pwm.sv
module syscon_pwm
    import syscon_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DUTY_W-1:0] duty,
    output logic              pwm_out
);

    typedef struct packed {
        logic [DUTY_W-1:0] cnt;
        logic              out;
    } pwm_t;

    pwm_t pwm_d, pwm_q;

    always_comb begin
        pwm_d     = pwm_q;
        pwm_d.cnt = pwm_q.cnt + 1'b1;
        pwm_d.out = (pwm_q.cnt < duty);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwm_q <= '0;
        end else begin
            pwm_q <= pwm_d;
        end
    end

    assign pwm_out = pwm_q.out;

endmodule

// File: rtl/syscon_regs.sv
module syscon_regs
    import syscon_pkg::*;
#(
    parameter logic [DATA_W-1:0] IDENT_WORD  = 32'h5C0C_0A11,
    parameter int                NUM_BANKS   = 2,
    parameter int                PWM_PIN     = 15,
    parameter int                SYNC_STAGES = 2,
    localparam int               PAD_W       = NUM_BANKS * GPIO_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_waddr,
    input  logic [DATA_W/8-1:0]  bus_be,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [PAD_W-1:0]     pad_in,
    output logic [PAD_W-1:0]     pad_out,
    output logic [PAD_W-1:0]     pad_oe,
    input  logic [IRQ_N-1:0]     irq_src,
    output logic                 cpu_irq,
    output logic                 adc7_sel,
    output logic                 chan_mode
);

    typedef struct packed {
        logic [DATA_W-1:0] scratch;
        logic [IRQ_N-1:0]  mask;
        logic [CTL_W-1:0]  ctrl;
        logic              irq;
    } regs_t;

    regs_t regs_d, regs_q;

    logic              wr_en;
    logic              rd_en;
    logic [DATA_W-1:0] wmask;
    logic [DATA_W-1:0] rd_data;

    logic [GPIO_W-1:0] bank_level [NUM_BANKS];
    logic [PAD_W-1:0]  gp_dout;
    logic [PAD_W-1:0]  gp_oe;

    logic              pwm_en;
    logic [DUTY_W-1:0] pwm_duty;
    logic              pwm_wave;

    assign wr_en = bus_sel & bus_we;
    assign rd_en = bus_sel & ~bus_we;

    // ------------------------------------------------------------------
    // register next-state
    // ------------------------------------------------------------------
    always_comb begin
        wmask  = lane_mask(bus_be);
        regs_d = regs_q;

        if (wr_en) begin
            case (bus_waddr)
                W_SCRATCH: begin
                    regs_d.scratch = (regs_q.scratch & ~wmask)
                                   | (bus_wdata & wmask);
                end
                W_IRQ_MASK: begin
                    regs_d.mask = (regs_q.mask & ~wmask[IRQ_N-1:0])
                                | (bus_wdata[IRQ_N-1:0] & wmask[IRQ_N-1:0]);
                end
                W_CTRL: begin
                    regs_d.ctrl = (regs_q.ctrl & ~wmask[CTL_W-1:0])
                                | (bus_wdata[CTL_W-1:0] & wmask[CTL_W-1:0]);
                end
                default: begin
                end
            endcase
        end

        regs_d.irq = |(irq_src & regs_q.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    // ------------------------------------------------------------------
    // GPIO banks
    // ------------------------------------------------------------------
    for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
        logic set_hit;
        logic clr_hit;

        assign set_hit = wr_en && (bus_waddr == bank_word(gi));
        assign clr_hit = wr_en && (bus_waddr == bank_word(gi) + 1'b1);

        syscon_gpio_bank #(
            .SYNC_STAGES (SYNC_STAGES)
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_we (set_hit),
            .clr_we (clr_hit),
            .be     (bus_be),
            .wdata  (bus_wdata),
            .pad_in (pad_in[gi*GPIO_W +: GPIO_W]),
            .level  (bank_level[gi]),
            .dout   (gp_dout[gi*GPIO_W +: GPIO_W]),
            .oe     (gp_oe[gi*GPIO_W +: GPIO_W])
        );
    end

    // ------------------------------------------------------------------
    // pulse generator and pin takeover
    // ------------------------------------------------------------------
    assign pwm_en   = regs_q.ctrl[CTL_PWM_EN];
    assign pwm_duty = regs_q.ctrl[DUTY_W-1:0];

    syscon_pwm u_pwm (
        .clk     (clk),
        .rst_n   (rst_n),
        .duty    (pwm_duty),
        .pwm_out (pwm_wave)
    );

    always_comb begin
        pad_out = gp_dout;
        pad_oe  = gp_oe;
        if (pwm_en) begin
            pad_out[PWM_PIN] = pwm_wave;
            pad_oe[PWM_PIN]  = 1'b1;
        end
    end

    // ------------------------------------------------------------------
    // read mux
    // ------------------------------------------------------------------
    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            case (bus_waddr)
                W_IDENT:    rd_data = IDENT_WORD;
                W_SCRATCH:  rd_data = regs_q.scratch;
                W_IRQ_STAT: rd_data = {{(DATA_W-IRQ_N){1'b0}}, irq_src};
                W_IRQ_MASK: rd_data = {{(DATA_W-IRQ_N){1'b0}}, regs_q.mask};
                W_CTRL:     rd_data = {{(DATA_W-CTL_W){1'b0}}, regs_q.ctrl};
                default:    rd_data = '0;
            endcase
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (bus_waddr == bank_word(b)) begin
                    rd_data = {{(DATA_W-GPIO_W){1'b0}}, bank_level[b]};
                end
            end
        end
    end

    assign bus_rdata = rd_data;
    assign cpu_irq   = regs_q.irq;
    assign adc7_sel  = regs_q.ctrl[CTL_ADC_SEL];
    assign chan_mode = regs_q.ctrl[CTL_MODE];

endmodule

// File: rtl/syscon_regs_chk.sv
module syscon_regs_chk
    import syscon_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_waddr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [IRQ_N-1:0]  irq_src,
    input logic              cpu_irq,
    input logic              pin_out,
    input logic              pin_oe,
    input logic              pwm_en,
    input logic [DUTY_W-1:0] pwm_duty
);

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_src == '0) |=> !cpu_irq); // R9

    AST_STATUS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_waddr == 6'h09)
            |-> (bus_rdata == {{(DATA_W-IRQ_N){1'b0}}, irq_src})); // R8

    AST_CLEAR_UNREADABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && (bus_waddr == 6'h05 || bus_waddr == 6'h11))
            |-> (bus_rdata == '0)); // R7

    AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && (bus_waddr == 6'h06 || bus_waddr == 6'h0A))
            |-> (bus_rdata == '0)); // R13

    AST_PWM_OWNS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_en |-> pin_oe); // R11

    AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_en && pwm_duty == '0) |=> (!pwm_en || !pin_out)); // R12

endmodule

bind syscon_regs syscon_regs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_waddr (bus_waddr),
    .bus_rdata (bus_rdata),
    .irq_src   (irq_src),
    .cpu_irq   (cpu_irq),
    .pin_out   (pad_out[PWM_PIN]),
    .pin_oe    (pad_oe[PWM_PIN]),
    .pwm_en    (pwm_en),
    .pwm_duty  (pwm_duty)
);

// File: tb/syscon_regs_test.sv
`timescale 1ns/1ps
module syscon_regs_test;

    localparam logic [31:0] IDENT = 32'h5C0C_0A11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_waddr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic [16:0] irq_src = '0;
    logic        cpu_irq;
    logic        adc7_sel;
    logic        chan_mode;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    syscon_regs uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_waddr (bus_waddr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .irq_src   (irq_src),
        .cpu_irq   (cpu_irq),
        .adc7_sel  (adc7_sel),
        .chan_mode (chan_mode)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_waddr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_be = '0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_waddr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(6'h03, v); check("R1 scratch", v, 32'h0);
        rd(6'h12, v); check("R1 mask", v, 32'h0);
        rd(6'h0F, v); check("R1 ctrl", v, 32'h0);
        check("R1 pad_oe", pad_oe, 32'h0);
        check("R1 pad_out", pad_out, 32'h0);
        check("R1 irq", {31'h0, cpu_irq}, 32'h0);
    endtask

    task automatic t_ident();
        logic [31:0] v;
        rd(6'h00, v); check("R2 ident", v, IDENT);
        wr(6'h00, 32'hFFFF_FFFF, 4'hF);
        rd(6'h00, v); check("R2 ident after write", v, IDENT);
    endtask

    task automatic t_scratch();
        logic [31:0] v;
        wr(6'h03, 32'h1234_5678, 4'hF);
        rd(6'h03, v); check("R3 word", v, 32'h1234_5678);
        wr(6'h03, 32'hFFFF_ABFF, 4'b0010);
        rd(6'h03, v); check("R3 byte lane", v, 32'h1234_AB78);
    endtask

    task automatic t_gpio();
        wr(6'h04, 32'h0000_00F0, 4'b0011);
        check("R4 set", pad_out, 32'h0000_00F0);
        wr(6'h04, 32'h0000_0F00, 4'b0011);
        check("R4 set keeps zeros", pad_out, 32'h0000_0FF0);
        wr(6'h05, 32'h0000_0030, 4'b0011);
        check("R4 clear", pad_out, 32'h0000_0FC0);
        check("R4 no oe change", pad_oe, 32'h0);
        wr(6'h04, 32'h00FF_0000, 4'b1100);
        check("R5 oe set", pad_oe, 32'h0000_00FF);
        wr(6'h05, 32'h000F_0000, 4'b1100);
        check("R5 oe clear", pad_oe, 32'h0000_00F0);
        check("R5 data unchanged", pad_out, 32'h0000_0FC0);
        wr(6'h10, 32'h0000_A5A5, 4'b0011);
        check("R4 bank1 set", pad_out, 32'hA5A5_0FC0);
        wr(6'h10, 32'h0000_FFFF, 4'b0001);
        check("R4 bank1 byte lane", pad_out, 32'hA5FF_0FC0);
        wr(6'h10, 32'h8001_0000, 4'b1100);
        check("R5 bank1 oe", pad_oe, 32'h8001_00F0);
    endtask

    task automatic t_unreadable();
        logic [31:0] v;
        rd(6'h05, v); check("R7 bank0 clear word", v, 32'h0);
        rd(6'h11, v); check("R7 bank1 clear word", v, 32'h0);
        rd(6'h04, v); check("R7 oe-set half", {16'h0, v[31:16]}, 32'h0);
    endtask

    task automatic t_level();
        logic [31:0] v;
        @(negedge clk);
        pad_in = 32'h1234_ABCD;
        rd(6'h04, v); check("R6 one edge old", v, 32'h0);
        rd(6'h04, v); check("R6 bank0 level", v, 32'h0000_ABCD);
        rd(6'h10, v); check("R6 bank1 level", v, 32'h0000_1234);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        @(negedge clk);
        irq_src = 17'h1_0001;
        rd(6'h09, v); check("R8 status", v, 32'h0001_0001);
        check("R9 masked off", {31'h0, cpu_irq}, 32'h0);
        wr(6'h12, 32'hFFFF_FFFF, 4'hF);
        rd(6'h12, v); check("R9 mask width", v, 32'h0001_FFFF);
        check("R9 enabled", {31'h0, cpu_irq}, 32'h1);
        wr(6'h12, 32'h0000_0002, 4'hF);
        @(negedge clk);
        check("R9 other bit only", {31'h0, cpu_irq}, 32'h0);
        irq_src = 17'h0_0003;
        #1 check("R9 registered delay", {31'h0, cpu_irq}, 32'h0);
        @(negedge clk);
        check("R9 source rises", {31'h0, cpu_irq}, 32'h1);
        irq_src = '0;
        @(negedge clk);
        check("R9 source falls", {31'h0, cpu_irq}, 32'h0);
    endtask

    task automatic t_ctrl();
        logic [31:0] v;
        wr(6'h0F, 32'hFFFB_1234, 4'hF);
        rd(6'h0F, v); check("R10 readback", v, 32'h0003_1234);
        check("R10 mode pins", {30'h0, chan_mode, adc7_sel}, 32'h3);
        wr(6'h0F, 32'h0001_0000, 4'b0100);
        check("R10 mode pins lane", {30'h0, chan_mode, adc7_sel}, 32'h1);
        wr(6'h0F, 32'h0, 4'hF);
    endtask

    task automatic t_pwm();
        int hi;
        wr(6'h04, 32'h0000_8000, 4'b0011);   // gpio data bit 15 = 1, enable still 0
        wr(6'h0F, 32'h0004_0000, 4'hF);      // enable, duty 0
        check("R11 oe forced", {31'h0, pad_oe[15]}, 32'h1);
        hi = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            hi += int'(pad_out[15]);
        end
        check("R12 zero duty", hi, 32'd0);
        check("R11 other pins", pad_out & 32'h0000_7FFF, 32'h0000_0FC0);
        wr(6'h0F, 32'h0004_4000, 4'hF);
        @(negedge clk);
        hi = 0;
        for (int i = 0; i < 65536; i++) begin
            @(negedge clk);
            hi += int'(pad_out[15]);
        end
        check("R12 duty count", hi, 32'h4000);
        wr(6'h0F, 32'h0, 4'hF);
        check("R11 released data", {31'h0, pad_out[15]}, 32'h1);
        check("R11 released oe", {31'h0, pad_oe[15]}, 32'h0);
    endtask

    task automatic t_reserved();
        logic [31:0] v;
        logic [31:0] po;
        po = pad_out;
        wr(6'h06, 32'hFFFF_FFFF, 4'hF);
        wr(6'h0A, 32'hFFFF_FFFF, 4'hF);
        rd(6'h06, v); check("R13 read 0x18", v, 32'h0);
        rd(6'h0A, v); check("R13 read 0x28", v, 32'h0);
        rd(6'h03, v); check("R13 scratch kept", v, 32'h1234_AB78);
        check("R13 pads kept", pad_out, po);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ident();
        t_scratch();
        t_gpio();
        t_unreadable();
        t_level();
        t_irq();
        t_ctrl();
        t_pwm();
        t_reserved();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule